// File: doc/BRIEF.md
# Translation Cache with Permission Checking

This block keeps a small, fully associative set of recent virtual-page to physical-frame mappings in front of an external page-table walker. A requester presents a virtual address along with flags for write intent and user privilege. When the page is already cached, the physical address comes back combinationally in the same cycle. When it is not, the block stalls the requester, asks the walker for the mapping, stores the result and completes the access on the cycle the walker answers.

Every access is checked against the page's permissions, whether it hits or comes from a walk. A write to a page that is not writable faults, and so does a user-mode access to a page that is reserved for supervisor mode. Read-only shared pages and copy-on-write pages both rely on the write check. For shootdowns after a permission change, software can drop the cached mapping for one virtual page, or clear the whole cache in one cycle.

Top module: `tlb_xlate_cache`

## Requirements
- R1: On an accepted request whose page is cached, `resp_valid` is high in the same cycle and `resp_paddr` = {cached frame, `req_vaddr[PAGE_BITS-1:0]`}. No walk request is issued.
- R2: On an accepted request whose page is not cached, `walk_req_valid` rises on the next cycle with `walk_req_vpn` = `req_vaddr[VA_W-1:PAGE_BITS]`. The response is given in the cycle `walk_resp_valid` is high, and a later access to that page hits without a walk.
- R3: The cache holds ENTRIES (default 64) distinct pages at once. After ENTRIES distinct pages have been installed, all of them hit.
- R4: A request with `req_user`=1 to a page whose user bit is 0 sets `resp_prot_fault` and returns `resp_paddr` = 0.
- R5: A request with `req_write`=1 to a page whose writable bit is 0 sets `resp_prot_fault` and returns `resp_paddr` = 0.
- R6: A permission fault on a cached page leaves that page cached, so a later permitted access hits.
- R7: `inv_valid` with `inv_vpn` removes that page's mapping at the next edge. The next access to the page walks again and uses the new permissions.
- R8: `flush` clears every mapping at the next edge. Flush also suppresses an install that would happen in the same cycle.
- R9: A walker response with `walk_resp_fault`=1 gives `resp_page_fault`=1 and `resp_paddr`=0, and nothing is installed.
- R10: A new mapping goes into the lowest-numbered empty slot. When no slot is empty, it goes into the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one (mod ENTRIES) on each install made while the cache is full.
- R11: `req_ready` is low from the cycle after a miss is accepted up to and including the cycle of the walker response. After that it is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access made in user mode |
| resp_valid | output | 1 | Access completes this cycle |
| resp_paddr | output | PA_W | Physical address (0 on any fault) |
| resp_prot_fault | output | 1 | Permission violation |
| resp_page_fault | output | 1 | Walker reported no mapping |
| walk_req_valid | output | 1 | Walk requested, held until answered |
| walk_req_vpn | output | VA_W-PAGE_BITS | Page to walk |
| walk_resp_valid | input | 1 | Walker answer, one cycle |
| walk_resp_pfn | input | PA_W-PAGE_BITS | Frame found by the walk |
| walk_resp_writable | input | 1 | Page writable bit |
| walk_resp_user | input | 1 | Page user-accessible bit |
| walk_resp_fault | input | 1 | Walk found no valid mapping |
| inv_valid | input | 1 | Drop one page's mapping |
| inv_vpn | input | VA_W-PAGE_BITS | Page to drop |
| flush | input | 1 | Drop all mappings |

## Verification
The assertions assume that the walker answers only while `walk_req_valid` is high, with a single-cycle `walk_resp_valid` pulse, and that the requester follows valid/ready. They also assume that no page is ever cached twice, which holds only because installs happen solely after a miss. The bench walker therefore waits for a request, responds once after a fixed latency and then drops its pulse. The requester raises a new request only after `req_ready` has returned. Invalidates and flushes are issued only in idle cycles, so the behaviour when they overlap an install is left to the design's stated priority rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;

    // True when the access breaks the page's protection
    function automatic logic perm_violation(
        input logic is_write,
        input logic is_user,
        input logic pg_writable,
        input logic pg_user
    );
        return (is_user && !pg_user) || (is_write && !pg_writable);
    endfunction

endpackage

// File: rtl/tlb_cam.sv
// Parallel tag compare over all slots; reports per-slot hits and the lowest hit index.
module tlb_cam #(
    parameter int N = 64,
    parameter int W = 20,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hits,
    output logic                any_hit,
    output logic [IW-1:0]       hit_idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = valid[g] && (tags[g] == key);
    end

    assign any_hit = |hits;

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) hit_idx = IW'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
// Chooses the lowest empty slot, falling back to the round-robin pointer when full.
module tlb_victim #(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  valid,
    input  logic [IW-1:0] rr_ptr,
    output logic [IW-1:0] victim,
    output logic          full
);

    logic [IW-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IW'(i);
        end
    end

    assign full   = &valid;
    assign victim = full ? rr_ptr : free_idx;

endmodule

// File: rtl/tlb_xlate_cache.sv
module tlb_xlate_cache
    import tlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 64,
    localparam int VPN_W = VA_W - PAGE_BITS,
    localparam int PFN_W = PA_W - PAGE_BITS,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_prot_fault,
    output logic             resp_page_fault,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_resp_valid,
    input  logic [PFN_W-1:0] walk_resp_pfn,
    input  logic             walk_resp_writable,
    input  logic             walk_resp_user,
    input  logic             walk_resp_fault,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush
);

    typedef struct packed {
        tlb_state_e                     st;
        logic [VPN_W-1:0]               p_vpn;
        logic [PAGE_BITS-1:0]           p_off;
        logic                           p_wr;
        logic                           p_usr;
        logic [IDX_W-1:0]               rr;
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][VPN_W-1:0]  tag;
        logic [ENTRIES-1:0][PFN_W-1:0]  frame;
        logic [ENTRIES-1:0]             wable;
        logic [ENTRIES-1:0]             uable;
    } state_t;

    state_t s_d, s_q;

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] lk_hits;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic [ENTRIES-1:0] inv_hits;
    logic               inv_any;
    logic [IDX_W-1:0]   inv_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               vic_full;
    logic               accept;
    logic               do_install;

    assign lk_vpn = req_vaddr[VA_W-1:PAGE_BITS];

    tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_lookup (
        .valid   (s_q.vld),
        .tags    (s_q.tag),
        .key     (lk_vpn),
        .hits    (lk_hits),
        .any_hit (lk_any),
        .hit_idx (lk_idx)
    );

    tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_inval (
        .valid   (s_q.vld),
        .tags    (s_q.tag),
        .key     (inv_vpn),
        .hits    (inv_hits),
        .any_hit (inv_any),
        .hit_idx (inv_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid  (s_q.vld),
        .rr_ptr (s_q.rr),
        .victim (vic_idx),
        .full   (vic_full)
    );

    assign accept         = req_valid && (s_q.st == ST_IDLE);
    assign req_ready      = (s_q.st == ST_IDLE);
    assign walk_req_valid = (s_q.st == ST_WALK);
    assign walk_req_vpn   = s_q.p_vpn;

    always_comb begin
        logic viol;
        s_d             = s_q;
        resp_valid      = 1'b0;
        resp_paddr      = '0;
        resp_prot_fault = 1'b0;
        resp_page_fault = 1'b0;
        do_install      = 1'b0;
        viol            = 1'b0;

        if (accept) begin
            if (lk_any) begin
                viol            = perm_violation(req_write, req_user,
                                                 s_q.wable[lk_idx], s_q.uable[lk_idx]);
                resp_valid      = 1'b1;
                resp_prot_fault = viol;
                resp_paddr      = viol ? '0 : {s_q.frame[lk_idx], req_vaddr[PAGE_BITS-1:0]};
            end else begin
                s_d.st    = ST_WALK;
                s_d.p_vpn = lk_vpn;
                s_d.p_off = req_vaddr[PAGE_BITS-1:0];
                s_d.p_wr  = req_write;
                s_d.p_usr = req_user;
            end
        end else if (s_q.st == ST_WALK && walk_resp_valid) begin
            s_d.st     = ST_IDLE;
            resp_valid = 1'b1;
            if (walk_resp_fault) begin
                resp_page_fault = 1'b1;
            end else begin
                viol            = perm_violation(s_q.p_wr, s_q.p_usr,
                                                 walk_resp_writable, walk_resp_user);
                resp_prot_fault = viol;
                resp_paddr      = viol ? '0 : {walk_resp_pfn, s_q.p_off};
                do_install      = 1'b1;
            end
        end

        if (inv_valid) begin
            s_d.vld = s_d.vld & ~inv_hits;
        end
        if (flush) begin
            s_d.vld = '0;
        end

        if (do_install && !flush && !(inv_valid && inv_vpn == s_q.p_vpn)) begin
            s_d.vld[vic_idx]   = 1'b1;
            s_d.tag[vic_idx]   = s_q.p_vpn;
            s_d.frame[vic_idx] = walk_resp_pfn;
            s_d.wable[vic_idx] = walk_resp_writable;
            s_d.uable[vic_idx] = walk_resp_user;
            if (vic_full) begin
                s_d.rr = (s_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : s_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a page is never held in two slots
    a_r3_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hits));

    // R1: a hit never starts a walk
    a_r1_hit_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_any) |=> !walk_req_valid);

    // R2: a miss walks the requested page
    a_r2_miss_walks: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_any) |=> (walk_req_valid && walk_req_vpn == $past(lk_vpn)));

    // R11: the requester is released after the walker answers
    a_r11_ready_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_resp_valid) |=> req_ready);

    // R6: a permission fault on a hit leaves the slot in place
    a_r6_fault_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_any && resp_prot_fault && !flush && !inv_valid) |=> s_q.vld[$past(lk_idx)]);

    // R8: flush empties the array
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.vld == '0));

    // R9: a walker fault installs nothing
    a_r9_no_install_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_resp_valid && walk_resp_fault)
            |=> ($countones(s_q.vld) <= $countones($past(s_q.vld))));

    // R7: an invalidated page is no longer cached at the next edge
    a_r7_inval_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_any && !walk_resp_valid) |=> !s_q.vld[$past(inv_idx)]);

endmodule

// File: tb/sim_tlb_xlate_cache.sv
`timescale 1ns/1ps
module sim_tlb_xlate_cache;

    localparam int N   = 64;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_prot_fault;
    logic        resp_page_fault;
    logic        walk_req_valid;
    logic [19:0] walk_req_vpn;
    logic        walk_resp_valid = 1'b0;
    logic [19:0] walk_resp_pfn = '0;
    logic        walk_resp_writable = 1'b0;
    logic        walk_resp_user = 1'b0;
    logic        walk_resp_fault = 1'b0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush = 1'b0;

    always #2.5 clk = ~clk;

    tlb_xlate_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_prot_fault(resp_prot_fault), .resp_page_fault(resp_page_fault),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_resp_valid(walk_resp_valid), .walk_resp_pfn(walk_resp_pfn),
        .walk_resp_writable(walk_resp_writable), .walk_resp_user(walk_resp_user),
        .walk_resp_fault(walk_resp_fault),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush(flush)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "reset";
    bit    done = 1'b0;

    // ---------------- page table kept by the bench ----------------
    bit ov_wr  [int];
    bit ov_usr [int];
    bit ov_flt [int];

    function automatic void pt_get(input int vpn, output int pfn, output bit w,
                                   output bit u, output bit f);
        pfn = (vpn * 13 + 7) & 32'hFFFFF;
        w = 1'b1; u = 1'b1; f = 1'b0;
        if (vpn >= 'h500) begin
            u = (vpn % 5) != 0;
            w = (vpn % 3) != 0;
            f = (vpn % 17) == 0;
        end
        if (ov_wr.exists(vpn))  w = ov_wr[vpn];
        if (ov_usr.exists(vpn)) u = ov_usr[vpn];
        if (ov_flt.exists(vpn)) f = ov_flt[vpn];
    endfunction

    // walker: answers once, LAT edges after the request is seen
    int wcnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            #1 walk_resp_valid = 1'b0; wcnt = 0;
        end else if (walk_resp_valid) begin
            #1 walk_resp_valid = 1'b0; wcnt = 0;
        end else if (walk_req_valid) begin
            int p; bit w; bit u; bit f; int v;
            v = int'(walk_req_vpn);
            wcnt++;
            if (wcnt == LAT) begin
                pt_get(v, p, w, u, f);
                #1;
                walk_resp_valid    = 1'b1;
                walk_resp_pfn      = p[19:0];
                walk_resp_writable = w;
                walk_resp_user     = u;
                walk_resp_fault    = f;
            end
        end else begin
            wcnt = 0;
        end
    end

    // ---------------- behavioural reference model ----------------
    bit m_v [N];
    int m_tag [N];
    int m_pfn [N];
    bit m_w [N];
    bit m_u [N];
    int m_rr = 0;
    bit m_busy = 1'b0;
    int m_pvpn = 0;
    int m_poff = 0;
    bit m_pwr = 1'b0;
    bit m_pusr = 1'b0;

    function automatic int m_find(input int vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
            m_rr = 0; m_busy = 1'b0;
        end else begin
            int h; bit inst; int vic; bit full;
            h = m_find(int'(req_vaddr[31:12]));
            inst = 1'b0;
            vic = -1;
            for (int i = 0; i < N; i++) if (!m_v[i] && vic < 0) vic = i;
            full = (vic < 0);
            if (!m_busy && req_valid && h < 0) begin
                m_busy = 1'b1;
                m_pvpn = int'(req_vaddr[31:12]);
                m_poff = int'(req_vaddr[11:0]);
                m_pwr  = req_write;
                m_pusr = req_user;
            end else if (m_busy && walk_resp_valid) begin
                m_busy = 1'b0;
                inst = !walk_resp_fault;
            end
            if (inv_valid)
                for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == int'(inv_vpn)) m_v[i] = 1'b0;
            if (flush)
                for (int i = 0; i < N; i++) m_v[i] = 1'b0;
            if (inst && !flush && !(inv_valid && int'(inv_vpn) == m_pvpn)) begin
                if (full) begin
                    vic = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
                m_v[vic]   = 1'b1;
                m_tag[vic] = m_pvpn;
                m_pfn[vic] = int'(walk_resp_pfn);
                m_w[vic]   = walk_resp_writable;
                m_u[vic]   = walk_resp_user;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_rv; bit e_pf; bit e_pg; logic [31:0] e_pa; bit e_rdy; bit mm; int h;
            bit viol;
            e_rv = 1'b0; e_pf = 1'b0; e_pg = 1'b0; e_pa = '0; e_rdy = !m_busy;
            h = m_find(int'(req_vaddr[31:12]));
            if (!m_busy && req_valid && h >= 0) begin
                viol = (req_user && !m_u[h]) || (req_write && !m_w[h]);
                e_rv = 1'b1; e_pf = viol;
                e_pa = viol ? 32'h0 : {m_pfn[h][19:0], req_vaddr[11:0]};
            end else if (m_busy && walk_resp_valid) begin
                e_rv = 1'b1;
                if (walk_resp_fault) e_pg = 1'b1;
                else begin
                    viol = (m_pusr && !walk_resp_user) || (m_pwr && !walk_resp_writable);
                    e_pf = viol;
                    e_pa = viol ? 32'h0 : {walk_resp_pfn, m_poff[11:0]};
                end
            end
            mm = (req_ready !== e_rdy) || (walk_req_valid !== m_busy) ||
                 (m_busy && walk_req_vpn !== m_pvpn[19:0]) ||
                 (resp_valid !== e_rv) ||
                 (e_rv && (resp_paddr !== e_pa || resp_prot_fault !== e_pf ||
                           resp_page_fault !== e_pg));
            vectors++;
            if (mm) begin
                miscompares++;
                $display("FAIL %s t=%0t: got rdy=%b wv=%b rv=%b pa=%h pf=%b pg=%b; exp rdy=%b wv=%b rv=%b pa=%h pf=%b pg=%b",
                         cur_req, $time, req_ready, walk_req_valid, resp_valid, resp_paddr,
                         resp_prot_fault, resp_page_fault, e_rdy, m_busy, e_rv, e_pa, e_pf, e_pg);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic acc(input int vpn, input int off, input bit w, input bit u);
        req_vaddr = {vpn[19:0], off[11:0]};
        req_write = w;
        req_user  = u;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        while (!req_ready) begin @(posedge clk); #1; end
    endtask

    task automatic do_inv(input int vpn);
        inv_vpn = vpn[19:0]; inv_valid = 1'b1;
        @(posedge clk); #1;
        inv_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog: got run still active, exp finished");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (req_ready !== 1'b1 || walk_req_valid !== 1'b0 || resp_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R11 reset: got rdy=%b wv=%b rv=%b exp 1 0 0",
                     req_ready, walk_req_valid, resp_valid);
        end
        @(posedge clk); #1;

        cur_req = "R2";  acc('h10, 'h123, 0, 1);
        cur_req = "R1";  acc('h10, 'h456, 1, 1);
        cur_req = "R11"; acc('h11, 'h000, 0, 0);

        cur_req = "R8";  do_flush(); acc('h10, 'h001, 0, 1);
        do_flush();
        cur_req = "R3";
        for (int i = 0; i < N; i++) acc('h100 + i, i, 0, 1);
        for (int i = 0; i < N; i++) acc('h100 + i, i + 1, 1, 0);
        cur_req = "R10";
        acc('h200, 'h7, 0, 0);
        acc('h100, 'h8, 0, 0);
        acc('h102, 'h9, 0, 0);
        acc('h101, 'ha, 0, 0);
        acc('h103, 'hb, 0, 0);

        do_flush();
        ov_usr['h300] = 1'b0;
        cur_req = "R4";  acc('h300, 'h20, 0, 1);
        acc('h300, 'h21, 0, 0);
        acc('h300, 'h22, 1, 1);
        cur_req = "R6";  acc('h300, 'h23, 0, 0);

        ov_wr['h301] = 1'b0;
        cur_req = "R5";  acc('h301, 'h30, 1, 0);
        acc('h301, 'h31, 0, 1);
        acc('h301, 'h32, 1, 1);

        cur_req = "R7";
        ov_wr['h301] = 1'b1;
        do_inv('h301);
        acc('h301, 'h33, 1, 1);
        acc('h301, 'h34, 1, 1);

        ov_flt['h400] = 1'b1;
        cur_req = "R9";  acc('h400, 'h40, 0, 0);
        acc('h400, 'h41, 0, 0);

        cur_req = "mixed";
        for (int k = 0; k < 500; k++) begin
            int r; int v;
            r = $urandom_range(0, 99);
            v = 'h500 + $urandom_range(0, 79);
            if (r < 8)       do_inv(v);
            else if (r < 10) do_flush();
            else             acc(v, $urandom_range(0, 4095), $urandom_range(0, 1), $urandom_range(0, 1));
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule